// File: doc/BRIEF.md
# Effective Address Calculation Engine

This block resolves the effective address of one instruction word for a 64-bit machine that also executes legacy 36-bit-style instruction words. Given a word, it extracts the opcode, the accumulator and the source register. It then walks the address chain and returns the final address with a one-cycle done pulse. Indexing reads a general register through a register-file read port. Indirection reads a pointer word through a memory read port and waits for the read-valid response.

Each word in the chain is decoded in one of two formats, chosen by its top bit. The legacy format has an 18-bit address and a 4-bit index field. The native format has a 32-bit address, and it switches to a 41-bit long address only after a legacy-style native indirection has happened. A chain that starts native can fall back into legacy decoding, but it never returns to native. A programmable limit on chained memory fetches stops a looping chain and reports an error.

Bits are numbered 0 (most significant) to 63 (least significant) in this brief.

Top module: `eac_engine`

## Requirements
- R1: After reset, done_o, err_o, busy_o and mem_req_o are all 0.
- R2: A start word with bit 0 clear is a legacy word. Its opcode is bits 14–22, zero-extended to 10 bits. Its accumulator is bits 23–26, and the source register equals the accumulator. compat_o is 1. With bit 27 clear and bits 28–31 zero, the address is bits 46–63 zero-extended, and done_o rises 2 cycles after start is sampled.
- R3: In a legacy word, a nonzero index field (bits 28–31) adds that register's value to the address and keeps only the low 18 bits; done_o then rises 3 cycles after start. An index field of 0 means no indexing, even when register 0 is nonzero.
- R4: In a legacy word, bit 27 set fetches the word at the current address. That word is decoded in legacy format whatever its bit 0 is.
- R5: A start word with bit 0 set is a native word. Its opcode is bits 1–10 and its accumulator is bits 14–18. With bit 11 (N) clear, the source register is the accumulator; with N set, the source register is bits 23–31. compat_o is 0.
- R6: A native word's address is bits 32–63. It becomes the 41-bit field in bits 23–63 only when bit 13 (L), N and the sticky flag F are all 1. F is 0 at start.
- R7: In a native word with N clear and a nonzero register number in bits 23–31, that register is added to the address. With L clear the sum is truncated to 32 bits; with L set the full 64-bit sum is kept.
- R8: A native word with bit 12 (I) set and L clear sets F, fetches the word at the address and decodes it as a native pointer. A fetched word with bit 0 clear is decoded in legacy format from then on.
- R9: A native word with I and L set fetches the word at the address, and that whole word is the final address.
- R10: At most ind_limit_i memory fetches are made per instruction. A further indirection ends the instruction with done_o and err_o both high. A chain that needs exactly ind_limit_i fetches completes without error.
- R11: mem_req_o stays high with a stable mem_addr_o until mem_rvalid_i is seen. start_i is ignored while busy_o is high.
- R12: done_o is high for one cycle. The result outputs hold their values after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept instr_i when idle |
| instr_i | input | 64 | Instruction word |
| ind_limit_i | input | LIM_W | Maximum number of chained memory fetches |
| busy_o | output | 1 | Engine is working on an instruction |
| reg_addr_o | output | 9 | Register-file read address; held through the index cycle |
| reg_data_i | input | 64 | Register value for reg_addr_o |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 64 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 64 | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Fetch limit exceeded; valid with done_o |
| compat_o | output | 1 | Instruction decoded in legacy format |
| opcode_o | output | 10 | Decoded opcode |
| ac_o | output | 5 | Accumulator number |
| src_o | output | 9 | Source register number |
| ea_o | output | 64 | Effective address |

## Verification
With no index and no indirection, done_o is due two cycles after start_i is sampled. An index adds one cycle for the register read. Each indirection adds the memory wait plus two cycles: one for the request and one to decode the fetched word. The bench drives on falling edges and samples on falling edges. For chains with no memory access it checks the exact count of 2 or 3 cycles. For memory chains, whose response delay the bench's responder sets at random, it waits for done_o within a bound and then compares every result output against a reference walk of the same chain.

// File: rtl/eac_pkg.sv
package eac_pkg;
  localparam int XLEN   = 64;
  localparam int OP_W   = 10;
  localparam int AC_W   = 5;
  localparam int RN_W   = 9;
  localparam int CA_W   = 18;  // legacy address width
  localparam int NA_W   = 32;  // native short address width
  localparam int LA_W   = 41;  // native long address width
  localparam int CX_W   = 4;   // legacy index field width

  typedef enum logic [1:0] {IX_18, IX_32, IX_FULL} ix_mode_e;

  typedef enum logic [1:0] {ST_IDLE, ST_EVAL, ST_IDX, ST_MEM} eac_state_e;

  typedef struct packed {
    logic                use_c;  // word decoded in legacy format
    logic                ind;
    logic                lng;    // native L bit
    ix_mode_e            imode;
    logic [RN_W-1:0]     idx;    // 0 = no indexing
    logic [XLEN-1:0]     base;
  } ptr_dec_t;
endpackage

// File: rtl/eac_decode.sv
module eac_decode
  import eac_pkg::*;
(
  input  logic [XLEN-1:0] word_i,
  output logic            compat_o,
  output logic [OP_W-1:0] op_o,
  output logic [AC_W-1:0] ac_o,
  output logic [RN_W-1:0] rn_o
);
  logic unused_bits;
  assign unused_bits = ^{word_i[51:50], word_i[31:0]};

  always_comb begin
    compat_o = ~word_i[63];
    if (compat_o) begin
      op_o = {1'b0, word_i[49:41]};
      ac_o = {1'b0, word_i[40:37]};
      rn_o = {{(RN_W-AC_W){1'b0}}, ac_o};
    end else begin
      op_o = word_i[62:53];
      ac_o = word_i[49:45];
      rn_o = word_i[52] ? word_i[40:32] : {{(RN_W-AC_W){1'b0}}, ac_o};
    end
  end
endmodule

// File: rtl/eac_ptr.sv
module eac_ptr
  import eac_pkg::*;
(
  input  logic [XLEN-1:0] word_i,
  input  logic            cmode_i,
  input  logic            f_i,
  output ptr_dec_t        dec_o
);
  logic n_b, i_b, l_b;
  logic unused_bits;
  assign unused_bits = ^{word_i[62:53], word_i[49:41]};

  assign n_b = word_i[52];
  assign i_b = word_i[51];
  assign l_b = word_i[50];

  always_comb begin
    dec_o.use_c = cmode_i | ~word_i[63];
    if (dec_o.use_c) begin
      dec_o.ind   = word_i[36];
      dec_o.lng   = 1'b0;
      dec_o.imode = IX_18;
      dec_o.idx   = {{(RN_W-CX_W){1'b0}}, word_i[35:32]};
      dec_o.base  = {{(XLEN-CA_W){1'b0}}, word_i[CA_W-1:0]};
    end else begin
      dec_o.ind   = i_b;
      dec_o.lng   = l_b;
      dec_o.imode = l_b ? IX_FULL : IX_32;
      dec_o.idx   = n_b ? '0 : word_i[40:32];
      // long field only once F has been set by a traditional indirection
      if (l_b && n_b && f_i)
        dec_o.base = {{(XLEN-LA_W){1'b0}}, word_i[LA_W-1:0]};
      else
        dec_o.base = {{(XLEN-NA_W){1'b0}}, word_i[NA_W-1:0]};
    end
  end
endmodule

// File: rtl/eac_index.sv
module eac_index
  import eac_pkg::*;
(
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] xval_i,
  input  ix_mode_e        mode_i,
  output logic [XLEN-1:0] sum_o
);
  logic [XLEN-1:0] full;
  assign full = base_i + xval_i;

  always_comb begin
    unique case (mode_i)
      IX_18:   sum_o = {{(XLEN-CA_W){1'b0}}, full[CA_W-1:0]};
      IX_32:   sum_o = {{(XLEN-NA_W){1'b0}}, full[NA_W-1:0]};
      default: sum_o = full;
    endcase
  end
endmodule

// File: rtl/eac_engine.sv
module eac_engine
  import eac_pkg::*;
#(
  parameter int LIM_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [XLEN-1:0]  instr_i,
  input  logic [LIM_W-1:0] ind_limit_i,
  output logic             busy_o,
  output logic [RN_W-1:0]  reg_addr_o,
  input  logic [XLEN-1:0]  reg_data_i,
  output logic             mem_req_o,
  output logic [XLEN-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [XLEN-1:0]  mem_rdata_i,
  output logic             done_o,
  output logic             err_o,
  output logic             compat_o,
  output logic [OP_W-1:0]  opcode_o,
  output logic [AC_W-1:0]  ac_o,
  output logic [RN_W-1:0]  src_o,
  output logic [XLEN-1:0]  ea_o
);
  eac_state_e       state_q;
  logic [XLEN-1:0]  wd_q, ea_q;
  logic             cmode_q, f_q, fin_q, done_q, err_q, cpt_q;
  logic [LIM_W-1:0] cnt_q, lim_q;
  logic [OP_W-1:0]  op_q;
  logic [AC_W-1:0]  ac_q;
  logic [RN_W-1:0]  rn_q;

  logic             d_cpt;
  logic [OP_W-1:0]  d_op;
  logic [AC_W-1:0]  d_ac;
  logic [RN_W-1:0]  d_rn;
  ptr_dec_t         pd;
  logic [XLEN-1:0]  sum, next_e;

  eac_decode u_dec (
    .word_i  (instr_i),
    .compat_o(d_cpt),
    .op_o    (d_op),
    .ac_o    (d_ac),
    .rn_o    (d_rn)
  );

  eac_ptr u_ptr (
    .word_i (wd_q),
    .cmode_i(cmode_q),
    .f_i    (f_q),
    .dec_o  (pd)
  );

  eac_index u_idx (
    .base_i(pd.base),
    .xval_i(reg_data_i),
    .mode_i(pd.imode),
    .sum_o (sum)
  );

  assign next_e = (state_q == ST_IDX) ? sum : pd.base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wd_q    <= '0;
      ea_q    <= '0;
      cmode_q <= 1'b0;
      f_q     <= 1'b0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cpt_q   <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
      op_q    <= '0;
      ac_q    <= '0;
      rn_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            wd_q    <= instr_i;
            cmode_q <= d_cpt;
            f_q     <= 1'b0;
            fin_q   <= 1'b0;
            err_q   <= 1'b0;
            cnt_q   <= '0;
            lim_q   <= ind_limit_i;
            cpt_q   <= d_cpt;
            op_q    <= d_op;
            ac_q    <= d_ac;
            rn_q    <= d_rn;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL, ST_IDX: begin
          cmode_q <= pd.use_c;
          if (state_q == ST_EVAL && pd.idx != '0) begin
            state_q <= ST_IDX;
          end else if (pd.ind) begin
            if (cnt_q == lim_q) begin
              err_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              ea_q    <= next_e;
              cnt_q   <= cnt_q + 1'b1;
              fin_q   <= ~pd.use_c & pd.lng;
              if (~pd.use_c & ~pd.lng) f_q <= 1'b1;
              state_q <= ST_MEM;
            end
          end else begin
            ea_q    <= next_e;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_MEM: begin
          if (mem_rvalid_i) begin
            if (fin_q) begin
              ea_q    <= mem_rdata_i;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              wd_q    <= mem_rdata_i;
              state_q <= ST_EVAL;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign reg_addr_o = (state_q == ST_EVAL || state_q == ST_IDX) ? pd.idx : '0;
  assign mem_req_o  = (state_q == ST_MEM);
  assign mem_addr_o = ea_q;
  assign done_o     = done_q;
  assign err_o      = err_q & done_q;
  assign compat_o   = cpt_q;
  assign opcode_o   = op_q;
  assign ac_o       = ac_q;
  assign src_o      = rn_q;
  assign ea_o       = ea_q;

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  a_r11_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(opcode_o) && $stable(src_o));

  a_r12_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !busy_o);

  a_r10_fetch_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> cnt_q <= lim_q && cnt_q != '0);

  a_r3_legacy_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o && cmode_q |-> ea_o[XLEN-1:CA_W] == '0);

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && reg_addr_o == '0);
endmodule

// File: tb/eac_engine_test.sv
module eac_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] instr_i = '0;
  logic [3:0]  ind_limit_i = '0;
  logic        busy_o;
  logic [8:0]  reg_addr_o;
  logic [63:0] reg_data_i;
  logic        mem_req_o;
  logic [63:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;
  logic        done_o, err_o, compat_o;
  logic [9:0]  opcode_o;
  logic [4:0]  ac_o;
  logic [8:0]  src_o;
  logic [63:0] ea_o;

  int n_cmp = 0;
  int n_bad = 0;
  int mem_dly = 0;
  logic [63:0] regs [512];
  logic [63:0] mem_img [logic [63:0]];

  always #2.5 clk = ~clk;

  eac_engine #(.LIM_W(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .instr_i(instr_i),
    .ind_limit_i(ind_limit_i), .busy_o(busy_o), .reg_addr_o(reg_addr_o),
    .reg_data_i(reg_data_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .err_o(err_o), .compat_o(compat_o), .opcode_o(opcode_o), .ac_o(ac_o),
    .src_o(src_o), .ea_o(ea_o)
  );

  assign reg_data_i = regs[reg_addr_o];

  function automatic logic [63:0] mem_rd(input logic [63:0] a);
    if (mem_img.exists(a)) return mem_img[a];
    return (a * 64'h9E37_79B9_7F4A_7C15) ^ {a[31:0], a[63:32]};
  endfunction

  function automatic logic [63:0] mk_c(input logic [8:0] op, input logic [3:0] ac,
                                       input logic i, input logic [3:0] x, input logic [17:0] y);
    return {14'b0, op, ac, i, x, 14'b0, y};
  endfunction

  function automatic logic [63:0] mk_n(input logic [9:0] op, input logic n, input logic i,
                                       input logic l, input logic [4:0] ac,
                                       input logic [8:0] mid, input logic [31:0] lo);
    return {1'b1, op, n, i, l, ac, 4'b0, mid, lo};
  endfunction

  // reference walk of the address chain
  function automatic void ref_ea(input logic [63:0] ins, input int lim,
                                 output logic [9:0] op, output logic [4:0] ac,
                                 output logic [8:0] rn, output logic cpt,
                                 output logic [63:0] ea, output logic err);
    logic [63:0] w, e, s;
    logic cm, f;
    int cnt;
    w = ins; cm = !ins[63]; f = 1'b0; cnt = 0; err = 1'b0; ea = '0; cpt = cm;
    if (cm) begin
      op = {1'b0, ins[49:41]}; ac = {1'b0, ins[40:37]}; rn = {4'b0, ac};
    end else begin
      op = ins[62:53]; ac = ins[49:45]; rn = ins[52] ? ins[40:32] : {4'b0, ac};
    end
    for (int k = 0; k < 40; k++) begin
      if (!w[63]) cm = 1'b1;
      if (cm) begin
        e = {46'b0, w[17:0]};
        if (w[35:32] != 0) begin s = e + regs[w[35:32]]; e = {46'b0, s[17:0]}; end
        if (!w[36]) begin ea = e; return; end
        if (cnt == lim) begin err = 1'b1; return; end
        cnt++; w = mem_rd(e);
      end else begin
        e = (w[50] && w[52] && f) ? {23'b0, w[40:0]} : {32'b0, w[31:0]};
        if (!w[52] && w[40:32] != 0) begin
          s = e + regs[w[40:32]];
          e = w[50] ? s : {32'b0, s[31:0]};
        end
        if (!w[51]) begin ea = e; return; end
        if (cnt == lim) begin err = 1'b1; return; end
        cnt++;
        if (w[50]) begin ea = mem_rd(e); return; end
        f = 1'b1; w = mem_rd(e);
      end
    end
    err = 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] ins, input int lim, output int lat);
    @(negedge clk);
    instr_i = ins; ind_limit_i = lim[3:0]; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; lat = 1;
    while (!done_o && lat < 500) begin @(negedge clk); lat++; end
  endtask

  task automatic check_out(input string tag, input logic [63:0] ins, input int lim);
    logic [9:0] op; logic [4:0] ac; logic [8:0] rn; logic cpt, err;
    logic [63:0] ea;
    ref_ea(ins, lim, op, ac, rn, cpt, ea, err);
    chk(cpt ? "R2 opcode" : "R5 opcode", {54'b0, opcode_o}, {54'b0, op});
    chk(cpt ? "R2 ac" : "R5 ac", {59'b0, ac_o}, {59'b0, ac});
    chk(cpt ? "R2 src" : "R5 src", {55'b0, src_o}, {55'b0, rn});
    chk("R2 compat flag", {63'b0, compat_o}, {63'b0, cpt});
    chk("R10 err", {63'b0, err_o}, {63'b0, err});
    if (!err) chk(tag, ea_o, ea);
  endtask

  // memory responder
  initial begin
    int wc = 0;
    forever begin
      @(negedge clk);
      if (mem_rvalid_i) mem_rvalid_i = 1'b0;
      else if (mem_req_o) begin
        if (wc >= mem_dly) begin
          mem_rvalid_i = 1'b1; mem_rdata_i = mem_rd(mem_addr_o); wc = 0;
        end else wc++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog act=timeout exp=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int lat;
    logic [63:0] w, hold;
    void'($urandom(32'd4711));
    for (int i = 0; i < 512; i++) regs[i] = {$urandom, $urandom};
    regs[0] = 64'h0000_0000_0000_1000;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {63'b0, done_o}, 64'd0);
    chk("R1 err", {63'b0, err_o}, 64'd0);
    chk("R1 busy", {63'b0, busy_o}, 64'd0);
    chk("R1 mem_req", {63'b0, mem_req_o}, 64'd0);
    rst_n = 1'b1;

    // R2 plain legacy word, latency 2
    run(mk_c(9'h1A5, 4'h7, 1'b0, 4'h0, 18'h2_3456), 2, lat);
    chk("R2 opcode", {54'b0, opcode_o}, 64'h1A5);
    chk("R2 src", {55'b0, src_o}, 64'h7);
    chk("R2 ea", ea_o, 64'h2_3456);
    chk("R2 latency", lat, 2);
    // R12 hold after done
    hold = ea_o;
    @(negedge clk); chk("R12 done pulse", {63'b0, done_o}, 64'd0);
    repeat (2) @(negedge clk); chk("R12 hold", ea_o, hold);

    // R3 legacy indexing, wrap to 18 bits, latency 3
    regs[5] = 64'h1234_0000_0000_0010;
    run(mk_c(9'h011, 4'h2, 1'b0, 4'h5, 18'h3_FFF8), 2, lat);
    chk("R3 truncated index", ea_o, 64'h8);
    chk("R3 latency", lat, 3);
    // R3 index 0 ignores nonzero register 0
    run(mk_c(9'h012, 4'h2, 1'b0, 4'h0, 18'h0_0042), 2, lat);
    chk("R3 no index", ea_o, 64'h42);

    // R4 legacy indirect, fetched word with top bit set still legacy
    mem_img[64'h100] = 64'h8008_0000_0000_0777;
    run(mk_c(9'h013, 4'h1, 1'b1, 4'h0, 18'h0_0100), 1, lat);
    chk("R4 legacy indirect", ea_o, 64'h777);
    chk("R10 exact limit ok", {63'b0, err_o}, 64'd0);

    // R5 native N=0 / N=1
    run(mk_n(10'h2F1, 1'b0, 1'b0, 1'b0, 5'd19, 9'h000, 32'h10), 2, lat);
    chk("R5 opcode", {54'b0, opcode_o}, 64'h2F1);
    chk("R5 src=ac", {55'b0, src_o}, 64'd19);
    run(mk_n(10'h0F0, 1'b1, 1'b0, 1'b0, 5'd3, 9'h1C4, 32'h10), 2, lat);
    chk("R5 src field", {55'b0, src_o}, 64'h1C4);
    chk("R5 ac", {59'b0, ac_o}, 64'd3);

    // R6 long field locked while F=0
    run(mk_n(10'h3, 1'b1, 1'b0, 1'b1, 5'd1, 9'h1AB, 32'hDEAD_BEEF), 2, lat);
    chk("R6 short address", ea_o, 64'hDEAD_BEEF);
    // R6 / R8 traditional indirection sets F, unlocks long field
    mem_img[64'h200] = mk_n(10'h3, 1'b1, 1'b0, 1'b1, 5'd1, 9'h1AB, 32'hDEAD_BEEF);
    run(mk_n(10'h2, 1'b1, 1'b1, 1'b0, 5'd2, 9'h0, 32'h200), 2, lat);
    chk("R6 long address", ea_o, {23'b0, 9'h1AB, 32'hDEAD_BEEF});

    // R7 native indexing
    regs[9] = 64'h0000_0001_8000_0000;
    run(mk_n(10'h5, 1'b0, 1'b0, 1'b0, 5'd4, 9'd9, 32'h8000_0001), 2, lat);
    chk("R7 truncated sum", ea_o, 64'h1);
    chk("R7 latency", lat, 3);
    run(mk_n(10'h5, 1'b0, 1'b0, 1'b1, 5'd4, 9'd9, 32'h8000_0001), 2, lat);
    chk("R7 full sum", ea_o, 64'h2_0000_0001);

    // R8 drop into legacy decoding
    mem_img[64'h400] = mk_c(9'h0, 4'h0, 1'b0, 4'h0, 18'h1_2345);
    run(mk_n(10'h6, 1'b1, 1'b1, 1'b0, 5'd0, 9'h0, 32'h400), 2, lat);
    chk("R8 fall back", ea_o, 64'h1_2345);

    // R9 fullword indirect
    mem_img[64'h300] = 64'hA5A5_0000_1234_5678;
    run(mk_n(10'h4, 1'b1, 1'b1, 1'b1, 5'd3, 9'h0, 32'h300), 2, lat);
    chk("R9 fullword", ea_o, 64'hA5A5_0000_1234_5678);

    // R10 looping chain and zero limit
    mem_img[64'h55] = mk_c(9'h0, 4'h0, 1'b1, 4'h0, 18'h55);
    run(mk_c(9'h7, 4'h1, 1'b1, 4'h0, 18'h55), 3, lat);
    chk("R10 loop abort", {63'b0, err_o}, 64'd1);
    chk("R10 done with err", {63'b0, done_o}, 64'd1);
    run(mk_c(9'h013, 4'h1, 1'b1, 4'h0, 18'h0_0100), 0, lat);
    chk("R10 zero limit", {63'b0, err_o}, 64'd1);

    // R11 start while busy is ignored
    mem_dly = 6;
    w = mk_n(10'h4, 1'b1, 1'b1, 1'b1, 5'd3, 9'h0, 32'h300);
    @(negedge clk); instr_i = w; ind_limit_i = 4'd2; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (2) @(negedge clk);
    instr_i = mk_c(9'h1FF, 4'hF, 1'b0, 4'h0, 18'h1); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    for (int k = 0; k < 50 && !done_o; k++) @(negedge clk);
    chk("R11 busy start ignored", ea_o, 64'hA5A5_0000_1234_5678);
    chk("R11 opcode kept", {54'b0, opcode_o}, 64'h4);
    @(negedge clk);
    chk("R11 no second run", {63'b0, busy_o}, 64'd0);

    // random chains
    for (int t = 0; t < 400; t++) begin
      int lim;
      mem_dly = $urandom_range(0, 2);
      lim = $urandom_range(0, 6);
      w = {$urandom, $urandom};
      if (t % 4 == 0) w[35:32] = 4'h0;
      run(w, lim, lat);
      check_out(w[63] ? "R7 random native ea" : "R3 random legacy ea", w, lim);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule